// File: doc/BRIEF.md
# Self-testing wrapper with pseudorandom stimulus and signature check

This block wraps a small combinational circuit under test (CUT) so that the circuit can test itself on chip. With the test-mode select low, the CUT takes its operand from the normal data input bus, and its registered result appears on the normal data output bus. With the test-mode select high, a start pulse begins a self-test. A maximal-length linear feedback shift register feeds the CUT one new pattern per clock. A multiple-input signature register folds every CUT result into one word.

After a parameterised number of patterns the run stops and the done flag rises. The pass flag then reports whether the signature equals a stored fault-free reference. That reference is computed at elaboration from the same parameters. The running signature is always visible on a dedicated test data output, so an external tester can read it directly. The wrapper sits between a CUT and a tester that only drives a mode select and a start pulse.

Top module: `st_bist_wrap`

## Requirements
- R1: While rst_ni is low and after its release, done_o, pass_o, sig_o and ndo_o are all zero.
- R2: With test_mode_i low, ndo_o takes F(ndi_i) at each clock edge, where F(x) = (x XOR rotate-left-by-one(x)) + (x >> W/2) modulo 2^W. With test_mode_i high, ndo_o holds its value.
- R3: On a start, the pattern generator loads SEED (default 1). Each time a pattern is absorbed it shifts left, and the new bit 0 is the XOR of the state bits selected by TAPS (default 0xB8, which is bits 7, 5, 4 and 3). The state never becomes zero, and for W=8 it repeats only after 255 patterns.
- R4: A start in test mode clears sig_o to zero. Each absorbed pattern p updates the signature to {sig[W-2:0], XOR(sig & TAPS)} XOR F(p).
- R5: done_o rises exactly PAT_CNT clock edges after the edge that sampled the start. It stays high while test_mode_i stays high and no new start arrives. A start_i seen while test_mode_i is low has no effect.
- R6: pass_o is high only when done_o is high and sig_o equals GOLDEN. The default GOLDEN is the fault-free signature for the default parameters.
- R7: Dropping test_mode_i aborts a run. done_o is low one edge later, and the signature does not change afterwards until the next start.
- R8: A start during a run restarts it from the seed with a cleared signature, and PAT_CNT further edges are needed before done_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | 1 = self-test, 0 = normal operation |
| start_i | input | 1 | Single-cycle pulse that starts a self-test |
| ndi_i | input | W | Normal data input to the CUT |
| ndo_o | output | W | Registered normal data output of the CUT |
| done_o | output | 1 | Self-test finished |
| pass_o | output | 1 | Signature matched the reference |
| sig_o | output | W | Current signature (test data output) |

## Verification
The assertions assume that test_mode_i and start_i change only between clock edges. They also assume that a start pulse is meaningful only while test_mode_i is high, and that the all-zero seed is never configured. The stimulus drives every input on the falling edge. It keeps the default nonzero seed and pulses start for exactly one cycle, both in normal mode and in test mode. This exercises the ignored-start, abort and restart cases without ever holding start across a mode change.

// File: rtl/st_pkg.sv
package st_pkg;

  function automatic logic [31:0] width_mask(int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  // Fault-free CUT transfer function
  function automatic logic [31:0] cut_fn(logic [31:0] x_in, int w);
    logic [31:0] m, x, r;
    m = width_mask(w);
    x = x_in & m;
    r = ((x << 1) | (x >> (w - 1))) & m;
    return ((x ^ r) + (x >> (w / 2))) & m;
  endfunction

  function automatic logic [31:0] shift_fb(logic [31:0] x, logic [31:0] taps, int w);
    return ((x << 1) & width_mask(w)) | {31'd0, ^(x & taps)};
  endfunction

  // Known-good signature, evaluated at elaboration
  function automatic logic [31:0] ref_sig(int w, logic [31:0] taps, logic [31:0] seed, int n);
    logic [31:0] g, s;
    g = seed;
    s = '0;
    for (int i = 0; i < n; i++) begin
      s = shift_fb(s, taps, w) ^ cut_fn(g, w);
      g = shift_fb(g, taps, w);
    end
    return s;
  endfunction

endpackage

// File: rtl/st_lfsr.sv
module st_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (load_i) q <= SEED;
    else if (adv_i)  q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign q_o = q;

  a_r3_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni) q != '0)
    else $error("R3: generator reached the all-zero state");

endmodule

// File: rtl/st_cut.sv
module st_cut #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  assign y_o = W'(st_pkg::cut_fn(32'(x_i), W));
endmodule

// File: rtl/st_misr.sv
module st_misr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    s <= '0;
    else if (clr_i) s <= '0;
    else if (en_i)  s <= {s[W-2:0], ^(s & TAPS)} ^ d_i;
  end

  assign sig_o = s;

  a_r4_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni) clr_i |=> s == '0)
    else $error("R4: signature not cleared");
  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !en_i) |=> $stable(s))
    else $error("R7: signature moved while idle");

endmodule

// File: rtl/st_bist_wrap.sv
module st_bist_wrap #(
  parameter int           W       = 8,
  parameter logic [W-1:0] TAPS    = 8'hB8,
  parameter logic [W-1:0] SEED    = 8'h01,
  parameter int           PAT_CNT = (1 << W) - 1,
  parameter logic [W-1:0] GOLDEN  = W'(st_pkg::ref_sig(W, 32'(TAPS), 32'(SEED), PAT_CNT))
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         test_mode_i,
  input  logic         start_i,
  input  logic [W-1:0] ndi_i,
  output logic [W-1:0] ndo_o,
  output logic         done_o,
  output logic         pass_o,
  output logic [W-1:0] sig_o
);
  localparam int CNT_W = $clog2(PAT_CNT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAT_CNT - 1);

  logic             run_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             go, adv;
  logic [W-1:0]     pat, cut_in, cut_out, sig;

  assign go  = test_mode_i & start_i;
  assign adv = test_mode_i & run_q & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!test_mode_i) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  st_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_gen (
    .clk_i, .rst_ni, .load_i(go), .adv_i(adv), .q_o(pat)
  );

  assign cut_in = test_mode_i ? pat : ndi_i;

  st_cut #(.W(W)) u_cut (.x_i(cut_in), .y_o(cut_out));

  st_misr #(.W(W), .TAPS(TAPS)) u_sig (
    .clk_i, .rst_ni, .clr_i(go), .en_i(adv), .d_i(cut_out), .sig_o(sig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ndo_o <= '0;
    else if (!test_mode_i) ndo_o <= cut_out;
  end

  assign sig_o  = sig;
  assign done_o = done_q;
  assign pass_o = done_q & (sig == GOLDEN);

  a_r5_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && test_mode_i && !start_i) |=> done_o)
    else $error("R5: done dropped early");
  a_r6_pass_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni) pass_o |-> done_o)
    else $error("R6: pass without done");
  a_r7_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni) !test_mode_i |=> !done_o)
    else $error("R7: done survived abort");
  a_r8_start_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni) go |=> !done_o)
    else $error("R8: done survived restart");
  a_r2_ndo_held_in_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
      test_mode_i |=> $stable(ndo_o))
    else $error("R2: ndo_o changed in test mode");

endmodule

// File: tb/st_bist_wrap_tb_top.sv
module st_bist_wrap_tb_top;
  localparam int W = 8;
  localparam int P0 = 255;
  localparam int P1 = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tm = 1'b0, st = 1'b0;
  logic [W-1:0] ndi = '0;
  logic [W-1:0] ndo [2], sig [2];
  logic done [2], pass [2];

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2ns clk = ~clk;

  st_bist_wrap #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .test_mode_i(tm), .start_i(st), .ndi_i(ndi),
    .ndo_o(ndo[0]), .done_o(done[0]), .pass_o(pass[0]), .sig_o(sig[0])
  );
  st_bist_wrap #(.W(W), .PAT_CNT(P1), .GOLDEN(8'h00)) dut_b (
    .clk_i(clk), .rst_ni(rst_ni), .test_mode_i(tm), .start_i(st), .ndi_i(ndi),
    .ndo_o(ndo[1]), .done_o(done[1]), .pass_o(pass[1]), .sig_o(sig[1])
  );

  function automatic int f_cut(int x);
    int rot = ((x << 1) | (x >> 7)) & 255;
    return ((x ^ rot) + (x >> 4)) & 255;
  endfunction
  function automatic int f_step(int x);
    int fb = ((x >> 7) ^ (x >> 5) ^ (x >> 4) ^ (x >> 3)) & 1;
    return ((x << 1) & 255) | fb;
  endfunction

  // Behavioural reference model
  int m_ndo [2], m_sig [2], m_gen [2], m_cnt [2], m_pc [2], gold [2];
  bit m_run [2], m_done [2];

  initial begin
    int g = 1, s = 0;
    for (int i = 0; i < P0; i++) begin
      s = f_step(s) ^ f_cut(g);
      g = f_step(g);
    end
    gold[0] = s;
    gold[1] = 0;
    m_pc[0] = P0;
    m_pc[1] = P1;
  end

  always @(posedge clk or negedge rst_ni) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_ni) begin
        m_ndo[k] = 0; m_sig[k] = 0; m_gen[k] = 1; m_cnt[k] = 0;
        m_run[k] = 0; m_done[k] = 0;
      end else if (!tm) begin
        m_ndo[k] = f_cut(int'(ndi));
        m_run[k] = 0; m_done[k] = 0;
      end else if (st) begin
        m_run[k] = 1; m_done[k] = 0; m_cnt[k] = 0; m_gen[k] = 1; m_sig[k] = 0;
      end else if (m_run[k]) begin
        m_sig[k] = f_step(m_sig[k]) ^ f_cut(m_gen[k]);
        m_gen[k] = f_step(m_gen[k]);
        m_cnt[k]++;
        if (m_cnt[k] == m_pc[k]) begin
          m_run[k] = 0; m_done[k] = 1;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      for (int k = 0; k < 2; k++) begin
        check("R2 ndo", int'(ndo[k]), m_ndo[k]);
        check("R3/R4 sig", int'(sig[k]), m_sig[k]);
        check("R5/R7/R8 done", int'(done[k]), int'(m_done[k]));
        check("R6 pass", int'(pass[k]), int'(m_done[k] && (m_sig[k] == gold[k])));
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_start();
    st = 1'b1; tick(1); st = 1'b0;
  endtask

  initial begin
    tick(3);
    // R1: outputs quiet in reset
    for (int k = 0; k < 2; k++) begin
      check("R1 done", int'(done[k]), 0);
      check("R1 pass", int'(pass[k]), 0);
      check("R1 sig", int'(sig[k]), 0);
      check("R1 ndo", int'(ndo[k]), 0);
    end
    rst_ni = 1'b1;
    tick(1);
    // R2: normal mode with varied operands, including extremes
    ndi = 8'hFF; tick(1);
    ndi = 8'h00; tick(1);
    ndi = 8'h80; tick(1);
    for (int i = 0; i < 30; i++) begin
      ndi = 8'($urandom);
      tick(1);
    end
    // R5: start ignored in normal mode
    pulse_start();
    tick(5);
    // Full run; R6 pass on dut_i, fail on dut_b
    tm = 1'b1;
    ndi = 8'h3C;
    tick(2);
    pulse_start();
    tick(P0 + 10);
    check("R6 full-run pass", int'(pass[0]), 1);
    check("R5 full-run done", int'(done[0]), 1);
    // R7: abort mid-run
    pulse_start();
    tick(50);
    tm = 1'b0;
    tick(4);
    tm = 1'b1;
    tick(10);
    check("R7 no done after abort", int'(done[0]), 0);
    // R8: restart during a run
    pulse_start();
    tick(100);
    pulse_start();
    tick(P0 + 5);
    check("R8 done after restart", int'(done[0]), 1);
    // Back to normal mode
    tm = 1'b0;
    for (int i = 0; i < 10; i++) begin
      ndi = 8'($urandom);
      tick(1);
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule